// File: doc/BRIEF.md
# Paged ROM/RAM and Shadow Screen Selector

This block decodes every address issued by an 8-bit processor with a 64 KB space and drives the chip selects for the memories and peripherals behind it. The top 16 KB goes to the operating-system ROM, apart from a three-page I/O hole. The 16 KB window below it is shared by a 12 KB paged RAM and the paged ROMs. The paged ROMs sit in five dual-bank sockets plus a language bank inside the system ROM. The lower 32 KB is normal RAM. Two registers in the I/O hole configure it. One holds a 4-bit ROM number and a paged-RAM enable. The other holds a shadow-mode flag.

In shadow mode the screen area 3000–7FFF has a second, parallel RAM bank. Whether a data access goes to that shadow bank depends on the operand address and also on where the current instruction was fetched. The block records the opcode-fetch address on each cycle where the processor's sync strobe is high. If that address lies in the display-driver code region, later cycles of the same instruction may reach shadow RAM. The display-driver code region is the operating-system driver range, or the top 4 KB of paged RAM while paged RAM is enabled. Each clock edge ends one bus cycle. Selects are combinational from the current address and the registered state.

Top module: `paged_bank_decoder`

## Requirements
- R1: Reset clears the ROM number, the paged-RAM enable, the shadow flag and the fetch-origin flag, so `vdusel` is 0. After reset a paged-window access selects nothing while `lang_low` is 0, and selects the system ROM lower half while `lang_low` is 1.
- R2: Addresses C000–FBFF and FF00–FFFF assert `sys_rom_cs` with `sys_rom_hi`=1 and no other select.
- R3: Addresses FC00–FEFF assert only `io_cs`. No ROM select is active, which keeps ROM outputs off the bus.
- R4: A write cycle (`wr_en`=1) to FE30 latches `wdata[3:0]` as the ROM number and `wdata[7]` as the paged-RAM enable. The new values take effect from the next cycle.
- R5: In 8000–BFFF, when no paged RAM is hit, ROM number n in 2..11 asserts `sock_cs[n/2-1]` and sets `sock_hi` to bit 0 of n. ROM numbers 12 and 13 select nothing.
- R6: With `lang_low`=0, ROM numbers 14 and 15 select the system ROM lower half (`sys_rom_cs`=1, `sys_rom_hi`=0) and 0/1 select nothing. With `lang_low`=1 the two pairs swap roles.
- R7: With the paged-RAM enable set, 8000–AFFF asserts only `pram_cs`, and B000–BFFF still decodes the latched ROM number as in R5/R6.
- R8: A write cycle to FE34 loads `wdata[7]` into the shadow flag, and `vdusel` equals that flag from the next cycle.
- R9: `shadow_cs` is 1 only when all of these hold: the shadow flag is set, the address is in 3000–7FFF, `sync` is 0, and the last opcode fetch was from display-driver code. Otherwise 0000–7FFF asserts `ram_cs`. The default driver range is C000–DFFF.
- R10: An opcode fetch from A000–AFFF counts as display-driver code only while the paged-RAM enable is set. Fetches from 8000–9FFF, from paged ROM at A000–AFFF, or from E000 upward do not count.
- R11: `ram_buf_en` is 1 for 0000–7FFF, for paged-RAM hits and for FE20, and 0 elsewhere.
- R12: An opcode-fetch cycle never selects shadow RAM. The fetch-origin flag keeps its value until the next `sync` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Processor address |
| wdata | input | 8 | Processor write data |
| wr_en | input | 1 | Current cycle is a write |
| sync | input | 1 | Current cycle is an opcode fetch |
| lang_low | input | 1 | 1: ROM numbers 0/1 select the language bank; 0: numbers 14/15 |
| sys_rom_cs | output | 1 | System ROM select |
| sys_rom_hi | output | 1 | System ROM 16 KB half (1 = operating system) |
| sock_cs | output | 5 | Paged ROM socket selects |
| sock_hi | output | 1 | 16 KB half select for the selected socket |
| pram_cs | output | 1 | 12 KB paged RAM select |
| io_cs | output | 1 | I/O page select |
| ram_cs | output | 1 | Normal RAM select for 0000–7FFF |
| shadow_cs | output | 1 | Shadow screen RAM select |
| ram_buf_en | output | 1 | RAM data buffer enable |
| vdusel | output | 1 | Shadow mode flag |

## Verification
A corrupted ROM number or paged-RAM enable appears on the first access to 8000–BFFF after it goes wrong, as the wrong socket, half or RAM select. It stays hidden for as long as the program touches only RAM, I/O or the OS area. A wrong fetch-origin flag appears only on a screen-area data access in shadow mode before the next `sync`, as normal RAM chosen instead of shadow RAM or the other way round. The bench therefore pairs each fetch with screen accesses in the cycles that follow it. A stuck shadow flag shows at once on `vdusel`.

// File: rtl/paged_bank_decoder.sv
module paged_bank_decoder #(
  parameter logic [15:0] DRV_LO       = 16'hC000,
  parameter logic [15:0] DRV_HI       = 16'hDFFF,
  parameter logic [15:0] ROMSEL_ADDR  = 16'hFE30,
  parameter logic [15:0] SHADOW_ADDR  = 16'hFE34,
  parameter logic [15:0] VIDPROC_ADDR = 16'hFE20,
  parameter int          NSOCK        = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      addr,
  input  logic [7:0]       wdata,
  input  logic             wr_en,
  input  logic             sync,
  input  logic             lang_low,
  output logic             sys_rom_cs,
  output logic             sys_rom_hi,
  output logic [NSOCK-1:0] sock_cs,
  output logic             sock_hi,
  output logic             pram_cs,
  output logic             io_cs,
  output logic             ram_cs,
  output logic             shadow_cs,
  output logic             ram_buf_en,
  output logic             vdusel
);

  logic [3:0] romnum_q;
  logic       pram_q, shadow_q, drv_q;
  logic       unused_wbits;

  assign unused_wbits = ^wdata[6:4];

  wire in_io     = (addr >= 16'hFC00) && (addr <= 16'hFEFF);
  wire in_os     = (addr[15:14] == 2'b11) && !in_io;
  wire in_paged  = (addr[15:14] == 2'b10);
  wire pram_hit  = in_paged && pram_q && (addr[13:12] != 2'b11);
  wire rom_win   = in_paged && !pram_hit;
  wire lang_pair = lang_low ? (romnum_q[3:1] == 3'd0) : (romnum_q[3:1] == 3'd7);
  wire in_screen = (addr >= 16'h3000) && (addr <= 16'h7FFF);
  wire drv_code  = ((addr >= DRV_LO) && (addr <= DRV_HI)) ||
                   (pram_q && (addr[15:12] == 4'hA));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      romnum_q <= '0;
      pram_q   <= 1'b0;
      shadow_q <= 1'b0;
      drv_q    <= 1'b0;
    end else begin
      if (sync) drv_q <= drv_code;
      if (wr_en && addr == ROMSEL_ADDR) begin
        romnum_q <= wdata[3:0];
        pram_q   <= wdata[7];
      end
      if (wr_en && addr == SHADOW_ADDR) shadow_q <= wdata[7];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NSOCK; g++) begin : g_sock
      assign sock_cs[g] = rom_win && (romnum_q[3:1] == 3'(g + 1));
    end
  endgenerate

  assign sock_hi    = (|sock_cs) && romnum_q[0];
  assign sys_rom_cs = in_os || (rom_win && lang_pair);
  assign sys_rom_hi = in_os;
  assign pram_cs    = pram_hit;
  assign io_cs      = in_io;
  assign shadow_cs  = shadow_q && in_screen && !sync && drv_q;
  assign ram_cs     = !addr[15] && !shadow_cs;
  assign ram_buf_en = !addr[15] || pram_hit || (addr == VIDPROC_ADDR);
  assign vdusel     = shadow_q;

  // R3
  io_no_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_cs |-> (!sys_rom_cs && !(|sock_cs) && !pram_cs));
  // R5
  sock_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sock_cs));
  // R9
  shadow_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_cs |-> (vdusel && !ram_cs && !pram_cs));
  // R12
  fetch_not_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> !shadow_cs);
  // R8
  shadow_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SHADOW_ADDR && !wdata[7]) |=> !vdusel);
  // R11
  pram_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pram_cs |-> ram_buf_en);

endmodule

// File: tb/tb_paged_bank_decoder.sv
module tb_paged_bank_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr_en = 1'b0, sync = 1'b0, lang_low = 1'b0;
  logic sys_rom_cs, sys_rom_hi, sock_hi, pram_cs, io_cs, ram_cs, shadow_cs, ram_buf_en, vdusel;
  logic [4:0] sock_cs;

  int checks = 0, failures = 0;
  logic [3:0] m_rom = '0;
  logic m_pram = 1'b0, m_sh = 1'b0, m_drv = 1'b0;

  always #10 clk = ~clk;

  paged_bank_decoder dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en), .sync(sync),
    .lang_low(lang_low), .sys_rom_cs(sys_rom_cs), .sys_rom_hi(sys_rom_hi), .sock_cs(sock_cs),
    .sock_hi(sock_hi), .pram_cs(pram_cs), .io_cs(io_cs), .ram_cs(ram_cs), .shadow_cs(shadow_cs),
    .ram_buf_en(ram_buf_en), .vdusel(vdusel)
  );

  function automatic logic is_drv(input logic [15:0] a, input logic pr);
    return (a >= 16'hC000 && a <= 16'hDFFF) || (pr && a[15:12] == 4'hA);
  endfunction

  // {sys_cs, sys_hi, sock[4:0], sock_hi, pram, io, ram, shadow, buf, vdusel}
  function automatic logic [13:0] model(input logic [15:0] a, input logic s, input logic ll,
                                        input logic [3:0] rn, input logic pr, input logic sh,
                                        input logic dq);
    logic sys, syshi, sk_hi, pm, io, rm, shd, bf;
    logic [4:0] sk;
    sys = 0; syshi = 0; sk = '0; sk_hi = 0; pm = 0; io = 0; rm = 0; shd = 0; bf = 0;
    if (a >= 16'hFC00 && a <= 16'hFEFF) io = 1;
    else if (a >= 16'hC000) begin sys = 1; syshi = 1; end
    else if (a >= 16'h8000) begin
      if (pr && a < 16'hB000) pm = 1;
      else if (rn >= 2 && rn <= 11) begin sk[rn/2 - 1] = 1; sk_hi = rn[0]; end
      else if (ll && rn <= 1) sys = 1;
      else if (!ll && rn >= 14) sys = 1;
    end else begin
      if (sh && !s && dq && a >= 16'h3000) shd = 1;
      else rm = 1;
    end
    bf = (a < 16'h8000) || pm || (a == 16'hFE20);
    return {sys, syshi, sk, sk_hi, pm, io, rm, shd, bf, sh};
  endfunction

  task automatic step(input logic [15:0] a, input logic [7:0] wd, input logic w,
                      input logic s, input string tag);
    logic [13:0] got, exp;
    @(negedge clk);
    addr = a; wdata = wd; wr_en = w; sync = s;
    #5;
    got = {sys_rom_cs, sys_rom_hi, sock_cs, sock_hi, pram_cs, io_cs, ram_cs, shadow_cs, ram_buf_en, vdusel};
    exp = model(a, s, lang_low, m_rom, m_pram, m_sh, m_drv);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s addr=%h sync=%0b got=%b exp=%b", tag, a, s, got, exp);
    end
    @(posedge clk);
    if (rst_n) begin
      if (s) m_drv = is_drv(a, m_pram);
      if (w && a == 16'hFE30) begin m_rom = wd[3:0]; m_pram = wd[7]; end
      if (w && a == 16'hFE34) m_sh = wd[7];
    end
  endtask

  function automatic string region_tag(input logic [15:0] a);
    if (a >= 16'hFC00 && a <= 16'hFEFF) return "R3";
    if (a >= 16'hC000) return "R2";
    if (a >= 16'h8000) return m_pram ? "R7" : "R5";
    return "R9";
  endfunction

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(16'h8000, 8'h00, 0, 0, "R1");
    step(16'h9000, 8'h00, 0, 0, "R1");
    lang_low = 1'b1;
    step(16'h8000, 8'h00, 0, 0, "R1");
    step(16'h0000, 8'h00, 0, 0, "R1");
    lang_low = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    step(16'hC123, 8'h00, 0, 0, "R2");
    step(16'hFFFF, 8'h00, 0, 0, "R2");
    step(16'hFF00, 8'h00, 0, 0, "R2");
    step(16'hFC00, 8'h00, 0, 0, "R3");
    step(16'hFEFF, 8'h00, 0, 0, "R3");
    step(16'hFE30, 8'h05, 1, 0, "R4");
    step(16'h8000, 8'h00, 0, 0, "R4");
    step(16'hBFFF, 8'h00, 0, 0, "R5");
    for (int ll = 0; ll < 2; ll++) begin
      lang_low = ll[0];
      for (int n = 0; n < 16; n++) begin
        step(16'hFE30, 8'(n), 1, 0, "R4");
        step(16'h9ABC, 8'h00, 0, 0, (n < 2 || n > 11) ? "R6" : "R5");
      end
    end
    lang_low = 1'b0;
    step(16'hFE30, 8'h8B, 1, 0, "R4");
    step(16'h8000, 8'h00, 0, 0, "R7");
    step(16'hAFFF, 8'h00, 0, 0, "R7");
    step(16'hB000, 8'h00, 0, 0, "R7");
    step(16'hFE34, 8'h80, 1, 0, "R8");
    step(16'h0000, 8'h00, 0, 0, "R8");
    step(16'hC100, 8'h00, 0, 1, "R12");
    step(16'h3000, 8'h00, 0, 0, "R9");
    step(16'h7FFF, 8'h00, 0, 0, "R9");
    step(16'h2FFF, 8'h00, 0, 0, "R9");
    step(16'h5000, 8'h00, 0, 0, "R12");
    step(16'h1000, 8'h00, 0, 1, "R9");
    step(16'h4000, 8'h00, 0, 0, "R9");
    step(16'hA100, 8'h00, 0, 1, "R10");
    step(16'h5000, 8'h00, 0, 0, "R10");
    step(16'h9100, 8'h00, 0, 1, "R10");
    step(16'h5000, 8'h00, 0, 0, "R10");
    step(16'hFE30, 8'h0B, 1, 0, "R4");
    step(16'hA100, 8'h00, 0, 1, "R10");
    step(16'h5000, 8'h00, 0, 0, "R10");
    step(16'hE000, 8'h00, 0, 1, "R10");
    step(16'h5000, 8'h00, 0, 0, "R10");
    step(16'hC000, 8'h00, 0, 1, "R12");
    step(16'h5000, 8'h00, 0, 1, "R12");
    step(16'hFE20, 8'h00, 0, 0, "R11");
    step(16'hFE21, 8'h00, 0, 0, "R11");
    step(16'h7FFF, 8'h00, 0, 0, "R11");
    step(16'hFE34, 8'h7F, 1, 0, "R8");
    step(16'hC000, 8'h00, 0, 1, "R8");
    step(16'h4000, 8'h00, 0, 0, "R9");

    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [7:0] d;
      logic s, w;
      int k;
      k = $urandom_range(0, 9);
      d = 8'($urandom);
      s = 1'b0; w = 1'b0;
      case (k)
        0: begin a = 16'hFE30; w = 1'b1; end
        1: begin a = 16'hFE34; w = 1'b1; end
        2, 3: begin a = 16'($urandom_range(16'h8000, 16'hDFFF)); s = 1'b1; end
        4, 5: a = 16'($urandom_range(16'h3000, 16'h7FFF));
        6: a = 16'($urandom_range(16'hFC00, 16'hFEFF));
        default: a = 16'($urandom);
      endcase
      if (k == 9) lang_low = d[0];
      step(a, d, w, s, region_tag(a));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule